// File: doc/BRIEF.md
# Parallel ADC Host Readout Controller

This block sits in the FPGA fabric next to a four-channel, 12-bit successive-approximation converter whose result leaves the converter as two bytes on an 8-bit parallel bus. When the host logic pulses a request with a channel number, the controller drives the two channel-address lines. It then pulls chip select and read/convert low together to start a conversion, and waits for the converter's busy flag to go low and then high again.

After busy rises, the controller enables the bus by holding chip select low with read/convert high. It reads the upper byte with byte-select low and the lower byte with byte-select high, waiting a bus-access time before each capture. It returns a sign-extended 16-bit sample together with the channel it came from and a one-cycle valid strobe. Busy may fail to complete its low-then-high cycle within a set number of clocks. In that case the controller raises a one-cycle timeout error and returns to idle. Starts are paced so that each new conversion begins at least one full acquire-plus-convert period after the previous one.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: During and right after reset, chip select and read/convert are high (idle), byte-select is low, the valid strobe and the timeout error are low, and ready is high.
- R2: A request accepted while ready drives the requested channel onto the address lines one cycle before chip select falls. The address holds unchanged for as long as chip select stays low. The converter sees the start as chip select and read/convert both low for START_CYC cycles.
- R3: The bus is read only after busy has been seen low and then high following the start. The read holds chip select low and read/convert high. Byte-select is low for ceil(BUS_NS/CLK_NS) cycles and then high for the same count. Byte-select is never high unless the bus is enabled.
- R4: The sample equals the 12-bit value {upper byte, upper nibble of lower byte}, sign-extended to 16 bits. The lower nibble of the lower byte is ignored, and the reported channel equals the requested one.
- R5: The valid strobe is high for exactly one cycle per completed conversion.
- R6: Busy may not complete its low-then-high sequence within TIMEOUT_CYC cycles of the start, whether it stays low or never falls. The controller then pulses the timeout error for one cycle, produces no sample, and returns to idle with chip select high.
- R7: Two conversion starts are separated by at least ceil(CYCLE_NS/CLK_NS) cycles, and ready is low from acceptance of a request until that interval has elapsed.
- R8: A request made while ready is low is ignored: it starts no conversion and does not change the channel of the conversion in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Conversion request, taken when ready is high |
| req_ch | input | 2 | Channel for the request |
| ready | output | 1 | Controller can accept a request |
| adc_ch | output | 2 | Channel address lines to the converter |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rc | output | 1 | Read/convert line: low starts, high reads |
| adc_byte | output | 1 | Byte-select: low upper byte, high lower byte |
| adc_bus | input | 8 | Converter parallel data bus |
| adc_busy | input | 1 | Converter busy flag, low while converting |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| smp_data | output | 16 | Sign-extended sample |
| smp_ch | output | 2 | Channel of the sample |
| tmo_err | output | 1 | One-cycle timeout error |

## Verification
Busy passes through a two-stage synchronizer. The valid strobe therefore follows busy's rise by the two synchronizer cycles, one state change and two bus-access windows: about 21 cycles with the defaults. The bench waits for the strobe within a bounded window and samples on the falling edge. The bench's converter model serves garbage until the bus has been enabled with an unchanged byte-select for eight cycles. A shortened access wait therefore shows up as a wrong sample, not a timing mismatch. The timeout error is expected TIMEOUT_CYC cycles after the converter saw the start, within a few cycles either way. Start spacing is measured in clock counts between the falling edges the model detects.

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl #(
  parameter int CLK_NS      = 10,
  parameter int BUS_NS      = 83,
  parameter int CYCLE_NS    = 25000,
  parameter int TIMEOUT_CYC = 3000,
  parameter int START_CYC   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [1:0]  req_ch,
  output logic        ready,
  output logic [1:0]  adc_ch,
  output logic        adc_cs_n,
  output logic        adc_rc,
  output logic        adc_byte,
  input  logic [7:0]  adc_bus,
  input  logic        adc_busy,
  output logic        smp_valid,
  output logic [15:0] smp_data,
  output logic [1:0]  smp_ch,
  output logic        tmo_err
);
  localparam int ACC  = (BUS_NS + CLK_NS - 1) / CLK_NS;
  localparam int PACE = (CYCLE_NS + CLK_NS - 1) / CLK_NS;
  localparam int CW   = $clog2(TIMEOUT_CYC + ACC + START_CYC + 2);
  localparam int PW   = $clog2(PACE + 1);

  typedef enum logic [2:0] {IDLE, ADDR, STRT, WAIT, RDHI, RDLO, RELS} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pace;
  logic [1:0]    busy_q;
  logic          seen_low;
  logic [7:0]    hi;
  logic [1:0]    ch;

  wire busy_s   = busy_q[1];
  wire acc_done = cnt == CW'(ACC - 1);

  assign ready    = (st == IDLE) && (pace == '0);
  assign adc_ch   = ch;
  assign adc_cs_n = !(st == STRT || st == RDHI || st == RDLO);
  assign adc_rc   = st != STRT;
  assign adc_byte = st == RDLO;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      pace      <= '0;
      busy_q    <= 2'b11;
      seen_low  <= 1'b0;
      hi        <= '0;
      ch        <= '0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
      smp_ch    <= '0;
      tmo_err   <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      tmo_err   <= 1'b0;
      busy_q    <= {busy_q[0], adc_busy};
      cnt       <= cnt + 1'b1;
      if (pace != '0) pace <= pace - 1'b1;
      case (st)
        IDLE: begin
          cnt <= '0;
          if (req && pace == '0) begin
            ch <= req_ch;
            st <= ADDR;
          end
        end
        ADDR: begin
          cnt  <= '0;
          pace <= PW'(PACE - 1);
          st   <= STRT;
        end
        STRT: begin
          seen_low <= 1'b0;
          if (cnt == CW'(START_CYC - 1)) st <= WAIT;
        end
        WAIT: begin
          if (!busy_s) seen_low <= 1'b1;
          if (seen_low && busy_s) begin
            st  <= RDHI;
            cnt <= '0;
          end else if (cnt >= CW'(TIMEOUT_CYC - 1)) begin
            tmo_err <= 1'b1;
            st      <= IDLE;
          end
        end
        RDHI: if (acc_done) begin
          hi  <= adc_bus;
          st  <= RDLO;
          cnt <= '0;
        end
        RDLO: if (acc_done) begin
          smp_data  <= {{4{hi[7]}}, hi, adc_bus[7:4]};
          smp_ch    <= ch;
          smp_valid <= 1'b1;
          st        <= RELS;
          cnt       <= '0;
        end
        RELS: if (acc_done) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rdout_ctrl_chk.sv
module adc_rdout_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic [1:0] adc_ch,
  input logic       adc_cs_n,
  input logic       adc_rc,
  input logic       adc_byte,
  input logic       smp_valid,
  input logic       tmo_err
);
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |=> !tmo_err && !smp_valid);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> $stable(adc_ch));
  // R3
  byte_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_byte |-> !adc_cs_n && adc_rc);
  // R7
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> adc_cs_n && adc_rc && !adc_byte);
endmodule

bind adc_rdout_ctrl adc_rdout_ctrl_chk u_chk (.*);

// File: tb/adc_rdout_ctrl_test.sv
module adc_rdout_ctrl_test;
  localparam int TMO = 120, PACE = 100, CONV = 40, MACC = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, req = 1'b0;
  logic [1:0] req_ch = '0;
  logic ready, cs_n, rc, bsel, valid, err;
  logic [1:0] adc_ch, sch;
  logic [15:0] data;
  logic [7:0] bus;
  logic busy = 1'b1;

  adc_rdout_ctrl #(.CLK_NS(10), .BUS_NS(83), .CYCLE_NS(1000), .TIMEOUT_CYC(TMO), .START_CYC(2)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_ch(req_ch), .ready(ready),
    .adc_ch(adc_ch), .adc_cs_n(cs_n), .adc_rc(rc), .adc_byte(bsel),
    .adc_bus(bus), .adc_busy(busy), .smp_valid(valid), .smp_data(data),
    .smp_ch(sch), .tmo_err(err));

  int cyc = 0, total = 0, bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [11:0] ch_val [4];
  logic stuck_lo = 1'b0, stuck_hi = 1'b0, comb_q = 1'b1, byte_q = 1'b0;
  int ccnt = 0, starts = 0, start_cyc = 0, acc = 0, bad_reads = 0;
  logic [1:0] conv_ch = '0;
  logic [11:0] conv_v = '0;

  always @(posedge clk) begin
    comb_q <= cs_n | rc;
    byte_q <= bsel;
    if (comb_q && !(cs_n | rc)) begin
      starts <= starts + 1;
      start_cyc <= cyc;
      conv_ch <= adc_ch;
      conv_v <= ch_val[adc_ch];
      if (!stuck_hi) begin busy <= 1'b0; ccnt <= CONV; end
    end else if (!busy && ccnt > 0) ccnt <= ccnt - 1;
    else if (!busy && !stuck_lo) busy <= 1'b1;
    if (!cs_n && rc) acc <= (bsel == byte_q) ? acc + 1 : 1;
    else acc <= 0;
    if (!cs_n && rc && !busy) bad_reads <= bad_reads + 1;
  end
  assign bus = (!cs_n && rc && acc >= MACC) ? (bsel ? {conv_v[3:0], 4'hC} : conv_v[11:4]) : 8'h5A;

  task automatic chk(input logic ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  function automatic logic [15:0] sx(input logic [11:0] v);
    int s = int'(v);
    if (v >= 12'd2048) s -= 4096;
    return 16'(s);
  endfunction

  task automatic wait_ready();
    for (int i = 0; i < 400 && !ready; i++) tick();
  endtask

  task automatic do_conv(input logic [1:0] c, input logic poke);
    int s0, ps, seen;
    wait_ready();
    s0 = starts; ps = start_cyc;
    req = 1'b1; req_ch = c; tick(); req = 1'b0;
    chk(!ready, "R7 ready low after accept", ready, 0);
    seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (poke && i == 20) begin req = 1'b1; req_ch = c + 2'd1; end
      else req = 1'b0;
      if (valid) seen = 1; else tick();
    end
    req = 1'b0;
    chk(seen == 1, "R3 sample produced", seen, 1);
    chk(data == sx(ch_val[c]), "R4 sample value", data, sx(ch_val[c]));
    chk(sch == c, "R4 sample channel", sch, c);
    chk(conv_ch == c, "R2 address at start", conv_ch, c);
    chk(starts == s0 + 1, "R2 one start", starts, s0 + 1);
    if (s0 > 0) chk(start_cyc - ps >= PACE, "R7 start spacing", start_cyc - ps, PACE);
    tick();
    chk(!valid, "R5 valid one cycle", valid, 0);
    if (poke) begin
      wait_ready(); tick(); tick();
      chk(starts == s0 + 1, "R8 busy request ignored", starts, s0 + 1);
    end
  endtask

  task automatic do_tmo(input string tag);
    int seen, vseen, ec;
    wait_ready();
    req = 1'b1; req_ch = 2'd3; tick(); req = 1'b0;
    seen = 0; vseen = 0; ec = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (valid) vseen = 1;
      if (err) begin seen = 1; ec = cyc; end else tick();
    end
    chk(seen == 1, {tag, " R6 timeout raised"}, seen, 1);
    chk(ec - start_cyc >= TMO - 4 && ec - start_cyc <= TMO + 4, {tag, " R6 timeout delay"}, ec - start_cyc, TMO);
    chk(vseen == 0, {tag, " R6 no sample"}, vseen, 0);
    tick();
    chk(!err && cs_n, {tag, " R6 back to idle"}, {err, cs_n}, 1);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    chk(0, "watchdog expired", cyc, 150000);
    report();
  end

  initial begin
    for (int k = 0; k < 4; k++) ch_val[k] = '0;
    tick(); tick();
    // R1
    chk(cs_n && rc && !bsel, "R1 bus idle in reset", {cs_n, rc, bsel}, 3'b110);
    chk(!valid && !err, "R1 flags low in reset", {valid, err}, 0);
    rst_n = 1'b1; tick();
    chk(ready, "R1 ready after reset", ready, 1);
    for (int v = 0; v < 10; v++) begin
      for (int c = 0; c < 4; c++) ch_val[c] = 12'((v * 1229 + c * 911 + (v == 1 ? 2047 : 0)) % 4096);
      if (v == 2) ch_val[0] = 12'h800;
      if (v == 3) ch_val[1] = 12'hFFF;
      if (v == 4) ch_val[2] = 12'h7FF;
      for (int c = 0; c < 4; c++) do_conv(2'(c), 1'b0);
    end
    ch_val[1] = 12'h9A3;
    do_conv(2'd1, 1'b1);
    stuck_lo = 1'b1; do_tmo("stuck low"); stuck_lo = 1'b0;
    stuck_hi = 1'b1; do_tmo("stuck high"); stuck_hi = 1'b0;
    ch_val[2] = 12'h3C5;
    do_conv(2'd2, 1'b0);
    chk(bad_reads == 0, "R3 no read while busy low", bad_reads, 0);
    report();
  end
endmodule